// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous, pipelined static memory. Reads and writes may be issued in any order on consecutive clock cycles, with no idle cycle needed when the direction changes. Every command input is captured on the rising clock edge. Read data leaves a registered output two enabled cycles after its command. Write data enters two enabled cycles after its address, so a write's data phase lines up with the slot a read would use for its result. The shared bidirectional data bus is split here into a write-data input and a read-data output, with a valid flag on the output.

A command carrying an external address is taken when the advance strobe is low and all three chip selects are active. With the strobe high, the block continues the current burst. It repeats the starting operation and steps the two low address bits in linear or interleaved order. An active-low clock enable freezes the whole block.

Before written data reaches the array, it waits one cycle in a write buffer. A read that hits that buffer gets the buffered bytes merged over the stored word. The memory therefore always behaves as if commands complete in the order they were issued.

Top module: `nowait_sram`

## Requirements
- R1: A read command taken at an enabled rising edge drives `rdata` with the word at its address, and drives `rvalid` high, after the second enabled rising edge that follows.
- R2: While `cke_n` is 1 at a rising edge, every input is ignored and all state holds, including `rdata` and `rvalid`. A write command presented during such a cycle leaves the memory unchanged.
- R3: Reads and writes may be mixed on back-to-back enabled cycles with no idle cycle. The data for a write is sampled from `wdata` at the second enabled edge after the edge that took its address. Two enabled cycles after a write command, `rvalid` is 0.
- R4: `be_n` is sampled together with its address. Byte i, bits [8i+7:8i] of the word, is written only when `be_n[i]` is 0. A write with `be_n` = 4'hF changes nothing.
- R5: A read issued right after a write to the same address returns the newly written bytes. Those bytes are merged with the stored bytes that the write did not touch.
- R6: A new command (`adv` = 0) is accepted only when `cs0_n` = 0, `cs1` = 1 and `cs2_n` = 0. Any other combination is a deselect. A deselect writes nothing, and `rvalid` is 0 two enabled cycles later.
- R7: With `adv` = 1 after an accepted command, each cycle repeats that command's operation. The address keeps the upper bits of the start address, and its two low bits are (start + k) mod 4 for the k-th continuation when `burst_ilv` = 0.
- R8: With `burst_ilv` = 1, the two low address bits of the k-th continuation are start XOR k.
- R9: A continuation cycle after a deselect, or after reset, is itself a deselect. During a continuation cycle the chip selects are ignored.
- R10: After reset, `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; 1 freezes the block |
| adv | input | 1 | 0 = new command with external address, 1 = continue burst |
| wr_n | input | 1 | 0 = write, 1 = read, for new commands |
| be_n | input | 4 | Active-low byte write enables |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data, two enabled cycles after its address |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | `rdata` carries a read result this cycle |

## Verification
The assertions assume that every input is at a known 0 or 1 from the end of reset onwards. They also assume `burst_ilv` does not change in the middle of a burst. The latency assertions follow only commands that carry an external address, so continuation cycles are covered by the scoreboard alone. The stimulus drives every input at the falling edge, holds `burst_ilv` constant across each burst, and reads only addresses it has fully written first. Because of that last rule, no expected value depends on the array's power-up contents.

// File: rtl/nowait_sram_pkg.sv
// Shared definitions for the zero-turnaround SRAM model.
// Assumes the burst counter spans the two low address bits.
package nowait_sram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low address bits of a burst step, linear or interleaved order.
    function automatic logic [BURST_W-1:0] burst_seq(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               ilv
    );
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/nowait_sram_cmd.sv
// Command stage: decodes new or continued commands and registers them.
// Assumes AW is wider than the burst field; en is the active-high clock enable.
module nowait_sram_cmd
    import nowait_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          adv,
    input  logic          wr_n,
    input  logic [NB-1:0] be_n,
    input  logic          sel,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    output op_e           s1_op,
    output logic [AW-1:0] s1_addr,
    output logic [NB-1:0] s1_be
);

    logic               b_act;
    logic               b_wr;
    logic [AW-1:0]      b_base;
    logic [BURST_W-1:0] b_cnt;
    logic [BURST_W-1:0] cnt_nx;
    op_e                op_nx;
    logic [AW-1:0]      addr_nx;

    // Choose this cycle's operation and effective address.
    always_comb begin
        cnt_nx  = b_cnt + 1'b1;
        op_nx   = OP_NONE;
        addr_nx = addr;
        if (!adv) begin
            if (sel) op_nx = wr_n ? OP_RD : OP_WR;
        end else if (b_act) begin
            op_nx   = b_wr ? OP_WR : OP_RD;
            addr_nx = {b_base[AW-1:BURST_W],
                       burst_seq(b_base[BURST_W-1:0], cnt_nx, ilv)};
        end
    end

    // Register the decoded command into the first pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s1_addr <= '0;
            s1_be   <= '0;
        end else if (en) begin
            s1_op   <= op_nx;
            s1_addr <= addr_nx;
            s1_be   <= ~be_n;
        end
    end

    // Track the running burst: its start, operation and step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_act  <= 1'b0;
            b_wr   <= 1'b0;
            b_base <= '0;
            b_cnt  <= '0;
        end else if (en) begin
            if (!adv) begin
                b_act  <= sel;
                b_wr   <= !wr_n;
                b_base <= addr;
                b_cnt  <= '0;
            end else if (b_act) begin
                b_cnt  <= cnt_nx;
            end
        end
    end

endmodule

// File: rtl/nowait_sram_pipe.sv
// Second command stage and the write buffer that captures late write data.
// Assumes wdata belongs to the write that sits in stage two at the enabled edge.
module nowait_sram_pipe
    import nowait_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 8,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  op_e           s1_op,
    input  logic [AW-1:0] s1_addr,
    input  logic [NB-1:0] s1_be,
    input  logic [DW-1:0] wdata,
    output op_e           s2_op,
    output logic [AW-1:0] s2_addr,
    output logic          wb_vld,
    output logic [AW-1:0] wb_addr,
    output logic [NB-1:0] wb_be,
    output logic [DW-1:0] wb_data
);

    logic [NB-1:0] s2_be;

    // Advance the command one stage on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_NONE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    // Capture write data for the stage-two write into the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld  <= 1'b0;
            wb_addr <= '0;
            wb_be   <= '0;
            wb_data <= '0;
        end else if (en) begin
            wb_vld  <= (s2_op == OP_WR);
            wb_addr <= s2_addr;
            wb_be   <= s2_be;
            wb_data <= wdata;
        end
    end

endmodule

// File: rtl/nowait_sram_array.sv
// Storage array with byte-wise commit and a registered read port that
// forwards bytes from the write buffer. The array itself is not reset.
module nowait_sram_array #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 8,
    localparam int DW = NB * BW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          wb_vld,
    input  logic [AW-1:0] wb_addr,
    input  logic [NB-1:0] wb_be,
    input  logic [DW-1:0] wb_data,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] stored;
    logic [DW-1:0] merged;
    logic          hit;

    assign stored = mem[rd_addr];
    assign hit    = wb_vld && (wb_addr == rd_addr);

    // Per byte: take the buffered byte when the pending write covers it.
    for (genvar i = 0; i < NB; i++) begin : g_fwd
        assign merged[i*BW +: BW] = (hit && wb_be[i]) ? wb_data[i*BW +: BW]
                                                      : stored[i*BW +: BW];
    end

    // Commit the buffered write into the array, one byte lane at a time.
    always_ff @(posedge clk) begin
        if (en && wb_vld) begin
            for (int i = 0; i < NB; i++) begin
                if (wb_be[i]) mem[wb_addr][i*BW +: BW] <= wb_data[i*BW +: BW];
            end
        end
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (en) begin
            rvalid <= rd_en;
            if (rd_en) rdata <= merged;
        end
    end

endmodule

// File: rtl/nowait_sram.sv
// Top of the zero-turnaround SRAM model: command decode, pipeline, array.
// Assumes burst_ilv is held steady during a burst.
module nowait_sram
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int DW = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] be_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);

    logic              en;
    logic              sel;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [NBYTES-1:0] s1_be;
    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic              wb_vld;
    logic [ADDR_W-1:0] wb_addr;
    logic [NBYTES-1:0] wb_be;
    logic [DW-1:0]     wb_data;

    assign en  = !cke_n;
    assign sel = !cs0_n && cs1 && !cs2_n;

    nowait_sram_cmd #(.AW(ADDR_W), .NB(NBYTES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .en(en), .adv(adv), .wr_n(wr_n),
        .be_n(be_n), .sel(sel), .ilv(burst_ilv), .addr(addr),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
    );

    nowait_sram_pipe #(.AW(ADDR_W), .NB(NBYTES), .BW(BYTE_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .en(en),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be), .wdata(wdata),
        .s2_op(s2_op), .s2_addr(s2_addr),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_be(wb_be), .wb_data(wb_data)
    );

    nowait_sram_array #(.AW(ADDR_W), .NB(NBYTES), .BW(BYTE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .en(en),
        .rd_en(s2_op == OP_RD), .rd_addr(s2_addr),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_be(wb_be), .wb_data(wb_data),
        .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: rtl/nowait_sram_chk.sv
// Property checker for nowait_sram, attached by bind. It tracks commands
// that carry an external address through two enabled edges of its own.
module nowait_sram_chk
    import nowait_sram_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke_n,
    input logic          adv,
    input logic          wr_n,
    input logic          cs0_n,
    input logic          cs1,
    input logic          cs2_n,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input op_e           s2_op,
    input logic          wb_vld
);

    logic       selected;
    logic [1:0] rd_sr;
    logic [1:0] wr_sr;
    logic [1:0] ds_sr;

    assign selected = !cs0_n && cs1 && !cs2_n;

    // Age new read, write and deselect commands over enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sr <= '0;
            wr_sr <= '0;
            ds_sr <= '0;
        end else if (!cke_n) begin
            rd_sr <= {rd_sr[0], !adv && selected && wr_n};
            wr_sr <= {wr_sr[0], !adv && selected && !wr_n};
            ds_sr <= {ds_sr[0], !adv && !selected};
        end
    end

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rvalid);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(rvalid) && $stable(rdata)));

    // R1
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && rd_sr[1]) |=> rvalid);

    // R3
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && wr_sr[1]) |=> !rvalid);

    // R3
    write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s2_op == OP_WR) |=> wb_vld);

    // R6
    deselect_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ds_sr[1]) |=> !rvalid);

endmodule

bind nowait_sram nowait_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .wr_n(wr_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .rdata(rdata), .rvalid(rvalid), .s2_op(s2_op), .wb_vld(wb_vld)
);

// File: tb/nowait_sram_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models the memory and queues expected
// outputs; the monitor compares them after each enabled edge.
module nowait_sram_test;

    localparam logic [2:0] SEL = 3'b010;   // {cs0_n, cs1, cs2_n}
    localparam logic [2:0] OFF = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0;
    logic        adv = 1'b0;
    logic        wr_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic        cs0_n = 1'b1;
    logic        cs1 = 1'b1;
    logic        cs2_n = 1'b0;
    logic        burst_ilv = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    always #4 clk = ~clk;

    nowait_sram uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .wr_n(wr_n),
        .be_n(be_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .burst_ilv(burst_ilv), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct {
        int          due;
        logic        v;
        logic [31:0] d;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          edge_cnt = 0;
    logic        en_edge = 1'b0;
    logic        mon_on = 1'b0;
    logic        prev_v = 1'b0;
    logic [31:0] prev_d = '0;
    logic [31:0] ref_mem [256];
    logic        b_act = 1'b0;
    logic        b_wr = 1'b0;
    logic [7:0]  b_base = '0;
    logic [1:0]  b_cnt = '0;
    logic [31:0] pipe0 = '0;
    logic [31:0] pipe1 = '0;

    // Count enabled edges after reset.
    always @(posedge clk) begin
        en_edge = !cke_n;
        if (rst_n && !cke_n) edge_cnt++;
    end

    // Monitor: compare due items after enabled edges, hold after stalls.
    always @(negedge clk) begin
        if (mon_on) begin
            if (en_edge) begin
                if (exp_q.size() > 0 && exp_q[0].due == edge_cnt) begin
                    item_t it;
                    logic  ok;
                    it = exp_q.pop_front();
                    checks++;
                    ok = it.v ? (rvalid === 1'b1 && rdata === it.d) : (rvalid === 1'b0);
                    if (!ok) begin
                        fails++;
                        $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                                 it.tag, rvalid, rdata, it.v, it.d);
                    end
                end
            end else begin
                checks++;
                if (rvalid !== prev_v || rdata !== prev_d) begin
                    fails++;
                    $display("FAIL R2: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                             rvalid, rdata, prev_v, prev_d);
                end
            end
            prev_v = rvalid;
            prev_d = rdata;
        end
    end

    // Driver: one cycle of stimulus plus the reference model's step.
    task automatic cyc(input logic ckn, input logic a, input logic wn,
                       input logic [3:0] ben, input logic [2:0] cs,
                       input logic [7:0] ad, input logic [31:0] d,
                       input string tag);
        logic       do_rd;
        logic       do_wr;
        logic [7:0] ea;
        item_t      it;
        cke_n = ckn; adv = a; wr_n = wn; be_n = ben;
        {cs0_n, cs1, cs2_n} = cs;
        addr = ad; wdata = pipe1;
        if (!ckn) begin
            do_rd = 1'b0; do_wr = 1'b0; ea = ad;
            if (!a) begin
                if (cs == SEL) begin
                    do_rd = wn; do_wr = !wn;
                    b_act = 1'b1; b_wr = !wn; b_base = ad; b_cnt = 2'd0;
                end else begin
                    b_act = 1'b0;
                end
            end else if (b_act) begin
                b_cnt = b_cnt + 2'd1;
                ea = {b_base[7:2], burst_ilv ? (b_base[1:0] ^ b_cnt)
                                             : (b_base[1:0] + b_cnt)};
                do_rd = !b_wr; do_wr = b_wr;
            end
            it.due = edge_cnt + 3;
            it.tag = tag;
            it.v   = do_rd;
            it.d   = do_rd ? ref_mem[ea] : 32'h0;
            if (do_wr) begin
                for (int i = 0; i < 4; i++)
                    if (!ben[i]) ref_mem[ea][i*8 +: 8] = d[i*8 +: 8];
            end
            exp_q.push_back(it);
            pipe1 = pipe0;
            pipe0 = d;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] ad, input logic [31:0] d,
                      input logic [3:0] ben, input string tag);
        cyc(1'b0, 1'b0, 1'b0, ben, SEL, ad, d, tag);
    endtask

    task automatic rd(input logic [7:0] ad, input string tag);
        cyc(1'b0, 1'b0, 1'b1, 4'hF, SEL, ad, 32'h0, tag);
    endtask

    task automatic cont(input logic [31:0] d, input logic [2:0] cs, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 4'h0, cs, 8'h00, d, tag);
    endtask

    task automatic nop(input string tag);
        cyc(1'b0, 1'b0, 1'b1, 4'hF, OFF, 8'h00, 32'h0, tag);
    endtask

    task automatic stall(input logic [7:0] ad);
        cyc(1'b1, 1'b0, 1'b0, 4'h0, SEL, ad, 32'hBAD0_BAD0, "R2");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: idle output after reset
        checks++;
        if (rvalid !== 1'b0) begin
            fails++;
            $display("FAIL R10: rvalid=%0b expected 0", rvalid);
        end
        prev_v = rvalid;
        prev_d = rdata;
        mon_on = 1'b1;

        // R3, R1: back-to-back writes, then back-to-back reads
        for (int i = 0; i < 8; i++) wr(8'h40 + 8'(i), 32'hA000_0000 + 32'(i) * 32'h1111, 4'h0, "R3");
        for (int i = 0; i < 8; i++) rd(8'h40 + 8'(i), "R1");

        // R3: strict alternation of writes and reads
        for (int i = 0; i < 6; i++) begin
            wr(8'h50 + 8'(i), 32'h5A5A_0000 ^ 32'(i), 4'h0, "R3");
            rd(8'h40 + 8'(i), "R3");
        end

        // R5: read right after write, then the committed value
        wr(8'h60, 32'h1234_5678, 4'h0, "R5");
        rd(8'h60, "R5");
        rd(8'h60, "R5");

        // R4: partial write merged on forward; all-masked write changes nothing
        wr(8'h60, 32'hAABB_CCDD, 4'b1010, "R4");
        rd(8'h60, "R4");
        wr(8'h61, 32'h0F0F_0F0F, 4'h0, "R4");
        wr(8'h61, 32'hFFFF_FFFF, 4'hF, "R4");
        rd(8'h61, "R4");
        rd(8'h60, "R4");

        // R6: each chip select off turns a write into a deselect
        cyc(1'b0, 1'b0, 1'b0, 4'h0, 3'b110, 8'h40, 32'hDEAD_0001, "R6");
        cyc(1'b0, 1'b0, 1'b0, 4'h0, 3'b000, 8'h40, 32'hDEAD_0002, "R6");
        cyc(1'b0, 1'b0, 1'b0, 4'h0, 3'b011, 8'h40, 32'hDEAD_0003, "R6");
        rd(8'h40, "R6");

        // R7: linear write burst and linear read burst
        burst_ilv = 1'b0;
        wr(8'h72, 32'h7000_0000, 4'h0, "R7");
        for (int k = 1; k < 4; k++) cont(32'h7000_0000 + 32'(k), SEL, "R7");
        rd(8'h73, "R7");
        rd(8'h70, "R7");
        rd(8'h72, "R7");
        cont(32'h0, SEL, "R7");
        cont(32'h0, SEL, "R7");
        cont(32'h0, SEL, "R7");

        // R8: interleaved write burst, checked by single reads and a burst
        burst_ilv = 1'b1;
        wr(8'h83, 32'h8000_0003, 4'h0, "R8");
        for (int k = 1; k < 4; k++) cont(32'h8000_0010 + 32'(k), SEL, "R8");
        burst_ilv = 1'b0;
        rd(8'h82, "R8");
        rd(8'h81, "R8");
        rd(8'h80, "R8");
        burst_ilv = 1'b1;
        rd(8'h81, "R8");
        cont(32'h0, SEL, "R8");
        cont(32'h0, SEL, "R8");
        cont(32'h0, SEL, "R8");
        burst_ilv = 1'b0;

        // R9: continue after deselect is a deselect; selects ignored mid-burst
        nop("R9");
        cont(32'h9999_9999, SEL, "R9");
        rd(8'h44, "R9");
        cont(32'h0, OFF, "R9");

        // R2: stalls with ignored write commands around reads and writes
        wr(8'h90, 32'hC001_0090, 4'h0, "R2");
        stall(8'h90);
        stall(8'h91);
        wr(8'h91, 32'hC001_0091, 4'h0, "R2");
        stall(8'h90);
        rd(8'h90, "R2");
        stall(8'h91);
        rd(8'h91, "R2");
        rd(8'h72, "R2");
        stall(8'h72);
        cont(32'h0, SEL, "R2");
        cont(32'h0, SEL, "R2");

        // Drain the pipeline
        for (int i = 0; i < 4; i++) nop("R6");
        mon_on = 1'b0;
        finish_run();
    end

endmodule